// File: doc/BRIEF.md
# I2C Bit-Level Master Engine

This block is the bus-facing half of an I2C master. It drives SCL and SDA as open-drain lines, one primitive command at a time: START, STOP, byte write, byte read and bus recovery. The outputs are drive-low enables and the only bus input is the resolved SDA level. A host sequencer sends a transaction as a chain of these commands. For example, a register read is START, write address byte, write register byte, STOP, START, write address byte with the read bit set, read byte with NACK, STOP.

Commands enter over a valid/ready port. `cmd_ready` is high only while the engine is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. While the engine is busy, `cmd_ready` stays low and the host must hold its command until it is taken. A command is never dropped and never taken twice. When a command ends, `done` pulses for one cycle. On that cycle `cmd_ready` is high again, and `rd_data` and `ack_bit` hold their results.

SCL timing comes from `half_div`. Every phase of a bit lasts max(`half_div`,1) system clocks. A data bit is made of three phases: SCL low with SDA held, SCL low with SDA set, and SCL released. START and STOP add a fourth phase with SCL released, in which SDA makes its edge. The bus-recovery command gives nine clocks with SDA released and then a STOP, which frees a slave that is holding SDA low.

Top module: `iic_bit_master`

## Requirements
- R1: After reset, `scl_oe` and `sda_oe` are 0, `cmd_ready` is 1 and `done` is 0.
- R2: START (`cmd_op`=0) gives exactly one SCL high phase and one falling SDA edge while SCL is high. It leaves SCL released and SDA driven low.
- R3: STOP (`cmd_op`=1) gives exactly one SCL high phase and one rising SDA edge while SCL is high. It leaves both lines released.
- R4: Byte write (`cmd_op`=2) gives nine SCL high phases. The bus levels on the first eight equal `cmd_wdata`, most significant bit first. SDA is released on the ninth.
- R5: After a write, `ack_bit` is the SDA level sampled at the end of the ninth SCL high phase: 0 means ACK, 1 means NACK.
- R6: Byte read (`cmd_op`=3) gives nine SCL high phases and leaves the eight sampled bus bits in `rd_data`, first bit as MSB. On the ninth clock, SDA is driven low when `cmd_nack`=0 and released when `cmd_nack`=1.
- R7: Recovery (`cmd_op`=4) gives nine SCL high phases with SDA released, then a STOP. That is ten high phases in all, and it leaves both lines released.
- R8: SDA and SCL never change in the same cycle. SDA changes while SCL is released only in the START and STOP edges.
- R9: `done` rises exactly P*max(`half_div`,1) clocks after the accepting edge. P is 4 for START and STOP, 27 for write and read, and 31 for recovery. A `half_div` of 0 behaves as 1.
- R10: `cmd_ready` is low from the accepting edge until `done`. `done` lasts one cycle and coincides with `cmd_ready` returning high.
- R11: A `cmd_op` value above 4 is accepted, leaves the lines unchanged, and gives `done` on the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | DIV_W | System clocks per SCL phase (0 acts as 1) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 3 | Command code (0 START, 1 STOP, 2 write, 3 read, 4 recovery) |
| cmd_wdata | input | 8 | Byte to write |
| cmd_nack | input | 1 | Read: 0 sends ACK, 1 sends NACK |
| done | output | 1 | One-cycle command completion pulse |
| rd_data | output | 8 | Byte sampled by the last read |
| ack_bit | output | 1 | SDA level sampled on the last ninth clock |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Resolved SDA bus level |

## Verification
The assertions assume that `half_div` stays constant while a command runs. They also assume that `sda_in` is already synchronous to `clk` and that no other device drives SCL. The stimulus changes `half_div` only between commands. Its slave model changes its SDA pull only at a falling clock edge of the system clock while SCL is low, so the bus level is stable for the whole of each SCL high phase.

// File: rtl/iic_bit_pkg.sv
package iic_bit_pkg;

  localparam int BYTE_W     = 8;
  localparam int RCV_PULSES = 9;
  localparam int MAX_SLOTS  = (RCV_PULSES + 1 > BYTE_W + 1) ? RCV_PULSES + 1 : BYTE_W + 1;
  localparam int SLOT_W     = $clog2(MAX_SLOTS + 1);
  localparam int OP_W       = 3;

  typedef enum logic [OP_W-1:0] {
    OP_START   = 3'd0,
    OP_STOP    = 3'd1,
    OP_WRITE   = 3'd2,
    OP_READ    = 3'd3,
    OP_RECOVER = 3'd4
  } iic_op_e;

  typedef enum logic [1:0] {
    SK_START,
    SK_STOP,
    SK_BIT
  } slot_kind_e;

  // Line update applied when a phase is entered
  typedef struct packed {
    logic scl_rel;
    logic sda_set;
    logic sda_val;
  } line_cmd_t;

  function automatic logic op_known(input logic [OP_W-1:0] code);
    return code <= OP_W'(OP_RECOVER);
  endfunction

  function automatic int slot_count(input iic_op_e op);
    case (op)
      OP_WRITE, OP_READ: return BYTE_W + 1;
      OP_RECOVER:        return RCV_PULSES + 1;
      default:           return 1;
    endcase
  endfunction

  function automatic slot_kind_e slot_kind(input iic_op_e op, input logic [SLOT_W-1:0] slot);
    case (op)
      OP_START:   return SK_START;
      OP_STOP:    return SK_STOP;
      OP_RECOVER: return (int'(slot) == RCV_PULSES) ? SK_STOP : SK_BIT;
      default:    return SK_BIT;
    endcase
  endfunction

  function automatic int phase_count(input slot_kind_e kind);
    return (kind == SK_BIT) ? 3 : 4;
  endfunction

  // SDA level (1 = released) for a data slot
  function automatic logic bit_level(input iic_op_e op, input logic [SLOT_W-1:0] slot,
                                     input logic [BYTE_W-1:0] wb, input logic nack);
    case (op)
      OP_WRITE: return (int'(slot) < BYTE_W) ? wb[BYTE_W-1-int'(slot)] : 1'b1;
      OP_READ:  return (int'(slot) < BYTE_W) ? 1'b1 : nack;
      default:  return 1'b1;
    endcase
  endfunction

  function automatic line_cmd_t line_at(input iic_op_e op, input logic [SLOT_W-1:0] slot,
                                        input logic [1:0] ph, input logic [BYTE_W-1:0] wb,
                                        input logic nack);
    line_cmd_t  r;
    slot_kind_e k;
    k         = slot_kind(op, slot);
    r.scl_rel = ph[1];
    r.sda_set = ph[0];
    case (k)
      SK_START: r.sda_val = (ph == 2'd1);
      SK_STOP:  r.sda_val = (ph == 2'd3);
      default:  r.sda_val = bit_level(op, slot, wb, nack);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/iic_phase_timer.sv
module iic_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  input  logic             run,
  output logic             expire
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim    = (half_div == '0) ? '0 : half_div - DIV_W'(1);
  assign expire = run && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || expire) cnt_q <= '0;
    else                     cnt_q <= cnt_q + DIV_W'(1);
  end

  a_r9_phase_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= lim));

endmodule

// File: rtl/iic_step_ctrl.sv
module iic_step_ctrl
  import iic_bit_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [OP_W-1:0]     cmd_op,
  input  logic                expire,
  output logic                busy,
  output logic                done,
  output iic_op_e             op_q,
  output logic [1:0]          phase_q,
  output logic                load,
  output iic_op_e             ld_op,
  output logic [SLOT_W-1:0]   ld_slot,
  output logic [1:0]          ld_phase,
  output logic                sample_bit,
  output logic                sample_ack
);
  logic [SLOT_W-1:0] slot_q;
  logic              last_phase, last_slot, finish, known;

  assign known      = op_known(cmd_op);
  assign last_phase = int'(phase_q) == phase_count(slot_kind(op_q, slot_q)) - 1;
  assign last_slot  = int'(slot_q) == slot_count(op_q) - 1;
  assign finish     = expire && last_phase && last_slot;

  assign load     = (accept && known) || (expire && !finish);
  assign ld_op    = accept ? iic_op_e'(cmd_op) : op_q;
  assign ld_slot  = accept ? '0 : (last_phase ? slot_q + SLOT_W'(1) : slot_q);
  assign ld_phase = (accept || last_phase) ? 2'd0 : phase_q + 2'd1;

  assign sample_bit = busy && (op_q == OP_READ) && (int'(slot_q) < BYTE_W) && (phase_q == 2'd2);
  assign sample_ack = busy && ((op_q == OP_READ) || (op_q == OP_WRITE)) &&
                      (int'(slot_q) == BYTE_W) && (phase_q == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      op_q    <= OP_STOP;
      slot_q  <= '0;
      phase_q <= 2'd0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        if (known) begin
          busy    <= 1'b1;
          op_q    <= iic_op_e'(cmd_op);
          slot_q  <= '0;
          phase_q <= 2'd0;
        end else begin
          done <= 1'b1;
        end
      end else if (expire) begin
        if (finish) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          slot_q  <= ld_slot;
          phase_q <= ld_phase;
        end
      end
    end
  end

  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/iic_line_drv.sv
module iic_line_drv
  import iic_bit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [BYTE_W-1:0] cmd_wdata,
  input  logic              cmd_nack,
  input  logic              load,
  input  iic_op_e           ld_op,
  input  logic [SLOT_W-1:0] ld_slot,
  input  logic [1:0]        ld_phase,
  output logic              scl_rel,
  output logic              sda_rel
);
  logic [BYTE_W-1:0] wb_q;
  logic              nack_q;
  line_cmd_t         nxt;

  assign nxt = line_at(ld_op, ld_slot, ld_phase, wb_q, nack_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_q    <= '0;
      nack_q  <= 1'b1;
      scl_rel <= 1'b1;
      sda_rel <= 1'b1;
    end else begin
      if (accept) begin
        wb_q   <= cmd_wdata;
        nack_q <= cmd_nack;
      end
      if (load) begin
        scl_rel <= nxt.scl_rel;
        if (nxt.sda_set) sda_rel <= nxt.sda_val;
      end
    end
  end

endmodule

// File: rtl/iic_rx_capture.sv
module iic_rx_capture
  import iic_bit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire,
  input  logic              sample_bit,
  input  logic              sample_ack,
  input  logic              sda_in,
  output logic [BYTE_W-1:0] rd_data,
  output logic              ack_bit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      ack_bit <= 1'b1;
    end else if (expire) begin
      if (sample_bit) rd_data <= {rd_data[BYTE_W-2:0], sda_in};
      if (sample_ack) ack_bit <= sda_in;
    end
  end

  a_r5_one_sample_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_bit && sample_ack));

endmodule

// File: rtl/iic_bit_master.sv
module iic_bit_master
  import iic_bit_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [BYTE_W-1:0] cmd_wdata,
  input  logic              cmd_nack,
  output logic              done,
  output logic [BYTE_W-1:0] rd_data,
  output logic              ack_bit,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              sda_in
);
  logic              busy, accept, expire, load, sample_bit, sample_ack;
  logic              scl_rel, sda_rel;
  logic [1:0]        phase_q, ld_phase;
  logic [SLOT_W-1:0] ld_slot;
  iic_op_e           op_q, ld_op;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign scl_oe    = !scl_rel;
  assign sda_oe    = !sda_rel;

  iic_phase_timer #(.DIV_W(DIV_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .run(busy), .expire(expire)
  );

  iic_step_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cmd_op(cmd_op), .expire(expire),
    .busy(busy), .done(done), .op_q(op_q), .phase_q(phase_q), .load(load),
    .ld_op(ld_op), .ld_slot(ld_slot), .ld_phase(ld_phase),
    .sample_bit(sample_bit), .sample_ack(sample_ack)
  );

  iic_line_drv lines_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cmd_wdata(cmd_wdata),
    .cmd_nack(cmd_nack), .load(load), .ld_op(ld_op), .ld_slot(ld_slot),
    .ld_phase(ld_phase), .scl_rel(scl_rel), .sda_rel(sda_rel)
  );

  iic_rx_capture rx_i (
    .clk(clk), .rst_n(rst_n), .expire(expire), .sample_bit(sample_bit),
    .sample_ack(sample_ack), .sda_in(sda_in), .rd_data(rd_data), .ack_bit(ack_bit)
  );

  a_r8_lines_not_together: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_oe) |-> $stable(sda_oe));

  a_r8_sda_edge_only_start_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !scl_oe) |-> (busy && phase_q == 2'd3));

  a_r2_start_leaves_sda_low: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_START) |-> (!scl_oe && sda_oe));

  a_r3_stop_leaves_released: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (op_q == OP_STOP || op_q == OP_RECOVER)) |-> (!scl_oe && !sda_oe));

endmodule

// File: tb/iic_bit_master_tb_top.sv
module iic_bit_master_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] half_div = 8'd1;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_wdata = 8'd0;
  logic       cmd_nack = 1'b0;
  logic       done, ack_bit, scl_oe, sda_oe, sda_in;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;

  // Slave model and bus monitor state
  logic       pull = 1'b0;
  int         mode = 0;        // 0 idle, 1 write target, 2 read source
  logic       slave_ack = 1'b0;
  logic [7:0] slave_byte = 8'd0;
  int         rises = 0, starts = 0, stops = 0, dual = 0;
  logic [9:0] bits = '0;
  logic       p_scl = 1'b1, p_sda = 1'b1;

  always #10 clk = ~clk;

  assign sda_in = !(sda_oe || pull);

  iic_bit_master dut_i (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_nack(cmd_nack),
    .done(done), .rd_data(rd_data), .ack_bit(ack_bit), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .sda_in(sda_in)
  );

  always @(negedge clk) begin
    logic scl_l, sda_l;
    scl_l = !scl_oe;
    sda_l = sda_in;
    if (scl_l != p_scl && sda_l != p_sda) dual++;
    else if (scl_l && !p_scl) begin
      rises++;
      bits = {bits[8:0], sda_l};
    end else if (scl_l && p_scl && sda_l != p_sda) begin
      if (!sda_l) starts++;
      else        stops++;
    end
    p_scl = scl_l;
    p_sda = sda_l;
    if (!scl_l) begin
      if (mode == 1)      pull <= (rises == 8) && slave_ack;
      else if (mode == 2) pull <= (rises < 8) && !slave_byte[7 - (rises % 8)];
      else                pull <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int phases_of(input int op);
    case (op)
      0, 1:    return 4;
      2, 3:    return 27;
      4:       return 31;
      default: return 0;
    endcase
  endfunction

  // Issues one command and returns the negedge count at which done was seen
  task automatic run_cmd(input int op, input logic [7:0] wd, input logic nk, output int n);
    bit busy_ok;
    @(negedge clk);
    rises = 0; starts = 0; stops = 0; dual = 0; bits = '0;
    cmd_op = op[2:0]; cmd_wdata = wd; cmd_nack = nk; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 1;
    busy_ok = 1'b1;
    while (!done && n < 4000) begin
      if (cmd_ready) busy_ok = 1'b0;
      @(negedge clk);
      n++;
    end
    chk(busy_ok, "R10 ready low while busy", 0, 0);
    chk(done && cmd_ready, "R10 done with ready", {done, cmd_ready}, 2'b11);
    @(negedge clk);
    chk(!done, "R10 done single cycle", done, 0);
  endtask

  task automatic timing_chk(input int op, input int n);
    int ne;
    ne = phases_of(op) * ((half_div == 0) ? 1 : int'(half_div)) + 1;
    chk(n == ne, "R9 done latency", n, ne);
    chk(dual == 0, "R8 simultaneous line change", dual, 0);
  endtask

  task automatic do_start();
    int n;
    mode = 0;
    run_cmd(0, 8'h00, 1'b0, n);
    timing_chk(0, n);
    chk(rises == 1 && starts == 1 && stops == 0, "R2 start shape", {rises, starts, stops}, 'h110);
    chk(!scl_oe && sda_oe, "R2 start end state", {scl_oe, sda_oe}, 2'b01);
  endtask

  task automatic do_stop();
    int n;
    mode = 0;
    run_cmd(1, 8'h00, 1'b0, n);
    timing_chk(1, n);
    chk(rises == 1 && starts == 0 && stops == 1, "R3 stop shape", {rises, starts, stops}, 'h101);
    chk(!scl_oe && !sda_oe, "R3 stop end state", {scl_oe, sda_oe}, 2'b00);
  endtask

  task automatic do_write(input logic [7:0] b, input logic ack);
    int n;
    mode = 1; slave_ack = ack;
    run_cmd(2, b, 1'b0, n);
    timing_chk(2, n);
    chk(rises == 9 && starts == 0 && stops == 0, "R4 write clocks", rises, 9);
    chk(bits[8:1] == b, "R4 write bits", bits[8:1], b);
    chk(bits[0] == !ack, "R4 ninth bit released", bits[0], !ack);
    chk(ack_bit == !ack, "R5 ack sampled", ack_bit, !ack);
  endtask

  task automatic do_read(input logic [7:0] b, input logic nk);
    int n;
    mode = 2; slave_byte = b;
    run_cmd(3, 8'h00, nk, n);
    timing_chk(3, n);
    chk(rises == 9 && starts == 0 && stops == 0, "R6 read clocks", rises, 9);
    chk(rd_data == b, "R6 read data", rd_data, b);
    chk(bits[0] == nk, "R6 master ack level", bits[0], nk);
  endtask

  task automatic do_recover();
    int n;
    mode = 0;
    run_cmd(4, 8'h00, 1'b0, n);
    timing_chk(4, n);
    chk(rises == 10 && stops == 1 && starts == 0, "R7 recovery shape", {rises, starts, stops}, 'hA01);
    chk(bits == 10'b1111111110, "R7 recovery sda levels", bits, 10'h3FE);
    chk(!scl_oe && !sda_oe, "R7 recovery end state", {scl_oe, sda_oe}, 2'b00);
  endtask

  task automatic do_unknown(input int op);
    int n;
    logic s0, d0;
    mode = 0;
    s0 = scl_oe; d0 = sda_oe;
    run_cmd(op, 8'hFF, 1'b1, n);
    chk(n == 1, "R11 unknown op done latency", n, 1);
    chk(scl_oe == s0 && sda_oe == d0 && rises == 0, "R11 lines untouched",
        {scl_oe, sda_oe}, {s0, d0});
  endtask

  initial begin : watchdog
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe && cmd_ready && !done, "R1 reset state",
        {scl_oe, sda_oe, cmd_ready, done}, 4'b0010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_oe && !sda_oe && cmd_ready && !done, "R1 state after release",
        {scl_oe, sda_oe, cmd_ready, done}, 4'b0010);

    for (int d = 0; d < 4; d++) begin
      half_div = 8'(d);
      do_start();
      do_write(8'hA5, 1'b1);
      do_write(8'h3C, 1'b0);
      do_read(8'h5A, 1'b0);
      do_read(8'hC3, 1'b1);
      do_stop();
      do_start();
      do_recover();
      do_unknown(5);
      do_unknown(7);
    end

    half_div = 8'd1;
    do_start();
    for (int b = 0; b < 256; b++) begin
      do_write(8'(b), b[0]);
      do_read(8'(b), b[1]);
    end
    do_stop();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule